// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small fully associative cache of address translations for one core. Each slot holds a virtual page number, a physical page number, an address-space tag, read/write/execute permission bits, a dirty flag and a valid flag. A lookup presents a virtual address, the current address-space tag and an access type. One cycle later the block reports a hit or a miss. On a permitted hit it also returns the physical address, which is the stored physical page number joined with the unchanged page offset. On a hit whose permissions refuse the access it returns a protection fault instead.

On a miss an external page walker resolves the translation and writes it back through the fill port. Slots carry their address-space tag, so a context switch needs no flush: slots from other spaces simply do not match. A flush port can clear every slot or only the slots of one address space. When no slot is free, a fill replaces the least recently used slot.

Top module: `asid_tlb`

## Requirements
- R1: While reset is held and after reset is released, no slot is valid. Every response output is 0, and the first lookup after reset misses.
- R2: A lookup sampled at a rising edge produces its result in the following cycle only. `rsp_valid_o` is high for that single cycle, and all other response outputs are 0 when it is low.
- R3: A lookup hits only if a valid slot holds both the same virtual page number (`lkp_vaddr_i[31:12]`) and the same address-space tag. Any other lookup reports `rsp_miss_o`=1 and `rsp_hit_o`=0.
- R4: On a permitted hit, `rsp_paddr_o` is the stored physical page number in bits 31:12 and `lkp_vaddr_i[11:0]` in bits 11:0. On a miss or a fault it is 0.
- R5: The access type is encoded as 0 read, 1 write, 2 execute and 3 reserved. Permission bit 0 allows read, bit 1 allows write and bit 2 allows execute. A hit whose bit for the access is clear, or any hit with type 3, reports `rsp_fault_o`=1 together with `rsp_hit_o`=1.
- R6: On a hit, `rsp_dirty_o` shows the slot's dirty flag as it stood before that access. A permitted write sets the flag. A faulting write leaves it unchanged. A fill loads the flag from `fill_dirty_i`.
- R7: A flush with `flush_all_i`=1 invalidates every slot.
- R8: A flush with `flush_all_i`=0 invalidates exactly the slots whose tag equals `flush_asid_i`. All other slots keep their translations.
- R9: A new fill takes the lowest-numbered invalid slot. When every slot is valid, it takes the slot least recently used as of the start of that cycle. Hits, including faulting hits, and fills count as uses, and a fill counts as more recent than a hit in the same cycle.
- R10: A fill whose page number and tag match a valid slot overwrites that slot in place. No other slot changes.
- R11: A fill presented in the same cycle as any flush is discarded.
- R12: A lookup in the same cycle as a fill or a flush sees the contents as they were before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_vaddr_i | input | 32 | Virtual address |
| lkp_asid_i | input | 8 | Current address-space tag |
| lkp_acc_i | input | 2 | Access type (0 read, 1 write, 2 exec, 3 reserved) |
| fill_valid_i | input | 1 | Write a translation |
| fill_vpn_i | input | 20 | Virtual page number to fill |
| fill_ppn_i | input | 20 | Physical page number to fill |
| fill_asid_i | input | 8 | Tag of the filled translation |
| fill_perm_i | input | 3 | Permissions {X,W,R} |
| fill_dirty_i | input | 1 | Initial dirty flag |
| flush_valid_i | input | 1 | Flush request |
| flush_all_i | input | 1 | 1: flush all slots, 0: flush by tag |
| flush_asid_i | input | 8 | Tag to flush |
| rsp_valid_o | output | 1 | Response present |
| rsp_hit_o | output | 1 | Translation found |
| rsp_miss_o | output | 1 | Translation absent; walker must fill |
| rsp_fault_o | output | 1 | Protection fault |
| rsp_paddr_o | output | 32 | Physical address |
| rsp_dirty_o | output | 1 | Dirty flag of the hit slot before access |

## Verification
Every lookup result is due exactly one clock after its request is sampled. Fill, flush, dirty and recency updates all take effect at that same edge, so they first show up in the response to a lookup issued one cycle later. The bench keeps a behavioural reference that advances at each rising edge. That reference uses only the pre-edge contents for the lookup and picks the fill victim before applying the cycle's hit. The bench compares every response output against this reference at each falling edge, which is half a cycle after the result is registered. Because of this, same-cycle lookup/fill/flush combinations and recency-driven evictions are checked at the exact cycle they become visible.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int PERM_BITS = 3;

  function automatic logic perm_allows(input logic [PERM_BITS-1:0] perm, input logic [1:0] acc);
    case (acc)
      ACC_READ:  return perm[0];
      ACC_WRITE: return perm[1];
      ACC_EXEC:  return perm[2];
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N_ENTRIES = 16,
  parameter int VPN_W     = 20,
  parameter int ASID_W    = 8,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic [N_ENTRIES-1:0][VPN_W-1:0]  vpn_i,
  input  logic [N_ENTRIES-1:0][ASID_W-1:0] asid_i,
  input  logic [N_ENTRIES-1:0]             valid_i,
  input  logic [VPN_W-1:0]                 key_vpn_i,
  input  logic [ASID_W-1:0]                key_asid_i,
  output logic                             hit_o,
  output logic [IDX_W-1:0]                 idx_o
);
  logic [N_ENTRIES-1:0] match;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (vpn_i[g] == key_vpn_i) && (asid_i[g] == key_asid_i);
  end

  assign hit_o = |match;

  // lowest index wins; duplicates are prevented by in-place refill
  always_comb begin
    idx_o = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--)
      if (match[i]) idx_o = IDX_W'(i);
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             t0_en_i,
  input  logic [IDX_W-1:0] t0_idx_i,
  input  logic             t1_en_i,
  input  logic [IDX_W-1:0] t1_idx_i,
  output logic [IDX_W-1:0] lru_idx_o
);
  // age 0 = most recent; ages always form a permutation
  logic [N_ENTRIES-1:0][IDX_W-1:0] age_q, age_mid, age_nxt;

  always_comb begin
    age_mid = age_q;
    if (t0_en_i) begin
      for (int i = 0; i < N_ENTRIES; i++)
        if (age_q[i] < age_q[t0_idx_i]) age_mid[i] = age_q[i] + 1'b1;
      age_mid[t0_idx_i] = '0;
    end
    age_nxt = age_mid;
    if (t1_en_i) begin
      for (int i = 0; i < N_ENTRIES; i++)
        if (age_mid[i] < age_mid[t1_idx_i]) age_nxt[i] = age_mid[i] + 1'b1;
      age_nxt[t1_idx_i] = '0;
    end
  end

  always_comb begin
    lru_idx_o = '0;
    for (int i = 0; i < N_ENTRIES; i++)
      if (age_q[i] == IDX_W'(N_ENTRIES - 1)) lru_idx_o = IDX_W'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else begin
      age_q <= age_nxt;
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int VPN_W     = 20,
  parameter int PPN_W     = 20,
  parameter int OFF_W     = 12,
  parameter int ASID_W    = 8,
  localparam int IDX_W    = $clog2(N_ENTRIES),
  localparam int VA_W     = VPN_W + OFF_W,
  localparam int PA_W     = PPN_W + OFF_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 lkp_valid_i,
  input  logic [VA_W-1:0]      lkp_vaddr_i,
  input  logic [ASID_W-1:0]    lkp_asid_i,
  input  logic [1:0]           lkp_acc_i,
  input  logic                 fill_valid_i,
  input  logic [VPN_W-1:0]     fill_vpn_i,
  input  logic [PPN_W-1:0]     fill_ppn_i,
  input  logic [ASID_W-1:0]    fill_asid_i,
  input  logic [PERM_BITS-1:0] fill_perm_i,
  input  logic                 fill_dirty_i,
  input  logic                 flush_valid_i,
  input  logic                 flush_all_i,
  input  logic [ASID_W-1:0]    flush_asid_i,
  output logic                 rsp_valid_o,
  output logic                 rsp_hit_o,
  output logic                 rsp_miss_o,
  output logic                 rsp_fault_o,
  output logic [PA_W-1:0]      rsp_paddr_o,
  output logic                 rsp_dirty_o
);
  logic [N_ENTRIES-1:0][VPN_W-1:0]     vpn_q;
  logic [N_ENTRIES-1:0][PPN_W-1:0]     ppn_q;
  logic [N_ENTRIES-1:0][ASID_W-1:0]    asid_q;
  logic [N_ENTRIES-1:0][PERM_BITS-1:0] perm_q;
  logic [N_ENTRIES-1:0]                valid_q, dirty_q;

  // lookup path
  logic             l_hit, l_ok, l_grant, l_fault, l_wr_set;
  logic [IDX_W-1:0] l_idx;

  tlb_cam #(.N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) i_lkp_cam (
    .vpn_i(vpn_q), .asid_i(asid_q), .valid_i(valid_q),
    .key_vpn_i(lkp_vaddr_i[VA_W-1:OFF_W]), .key_asid_i(lkp_asid_i),
    .hit_o(l_hit), .idx_o(l_idx)
  );

  assign l_ok     = perm_allows(perm_q[l_idx], lkp_acc_i);
  assign l_grant  = lkp_valid_i && l_hit && l_ok;
  assign l_fault  = lkp_valid_i && l_hit && !l_ok;
  assign l_wr_set = l_grant && (lkp_acc_i == ACC_WRITE);

  // fill path
  logic             f_hit, any_free, do_fill;
  logic [IDX_W-1:0] f_idx, free_idx, lru_idx, fill_idx;

  tlb_cam #(.N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) i_fill_cam (
    .vpn_i(vpn_q), .asid_i(asid_q), .valid_i(valid_q),
    .key_vpn_i(fill_vpn_i), .key_asid_i(fill_asid_i),
    .hit_o(f_hit), .idx_o(f_idx)
  );

  always_comb begin
    free_idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--)
      if (!valid_q[i]) free_idx = IDX_W'(i);
  end
  assign any_free = ~&valid_q;
  assign fill_idx = f_hit ? f_idx : (any_free ? free_idx : lru_idx);
  assign do_fill  = fill_valid_i && !flush_valid_i;

  tlb_lru #(.N_ENTRIES(N_ENTRIES)) i_lru (
    .clk_i, .rst_ni,
    .t0_en_i(lkp_valid_i && l_hit), .t0_idx_i(l_idx),
    .t1_en_i(do_fill),              .t1_idx_i(fill_idx),
    .lru_idx_o(lru_idx)
  );

  // slot storage
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
    logic wr_this, fl_this;
    assign wr_this = do_fill && (fill_idx == IDX_W'(g));
    assign fl_this = flush_valid_i && (flush_all_i || (asid_q[g] == flush_asid_i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vpn_q[g] <= '0; ppn_q[g] <= '0; asid_q[g] <= '0; perm_q[g] <= '0;
        valid_q[g] <= 1'b0; dirty_q[g] <= 1'b0;
      end else begin
        if (l_wr_set && (l_idx == IDX_W'(g))) dirty_q[g] <= 1'b1;
        if (wr_this) begin
          vpn_q[g]   <= fill_vpn_i;
          ppn_q[g]   <= fill_ppn_i;
          asid_q[g]  <= fill_asid_i;
          perm_q[g]  <= fill_perm_i;
          dirty_q[g] <= fill_dirty_i;
          valid_q[g] <= 1'b1;
        end
        if (fl_this) valid_q[g] <= 1'b0;
      end
    end
  end

  // registered response
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0; rsp_hit_o <= 1'b0; rsp_miss_o <= 1'b0;
      rsp_fault_o <= 1'b0; rsp_paddr_o <= '0; rsp_dirty_o <= 1'b0;
    end else begin
      rsp_valid_o <= lkp_valid_i;
      rsp_hit_o   <= lkp_valid_i && l_hit;
      rsp_miss_o  <= lkp_valid_i && !l_hit;
      rsp_fault_o <= l_fault;
      rsp_paddr_o <= l_grant ? {ppn_q[l_idx], lkp_vaddr_i[OFF_W-1:0]} : '0;
      rsp_dirty_o <= (lkp_valid_i && l_hit) ? dirty_q[l_idx] : 1'b0;
    end
  end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int N_ENTRIES = 16,
  parameter int OFF_W     = 12,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 lkp_valid_i,
  input logic [VA_W-1:0]      lkp_vaddr_i,
  input logic                 fill_valid_i,
  input logic                 flush_valid_i,
  input logic                 flush_all_i,
  input logic                 rsp_valid_o,
  input logic                 rsp_hit_o,
  input logic                 rsp_miss_o,
  input logic                 rsp_fault_o,
  input logic [PA_W-1:0]      rsp_paddr_o,
  input logic                 rsp_dirty_o,
  input logic [N_ENTRIES-1:0] valid_q
);
  // R2
  rsp_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i |=> rsp_valid_o);
  // R2
  rsp_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !rsp_hit_o && !rsp_miss_o && !rsp_fault_o && !rsp_dirty_o && rsp_paddr_o == '0);
  // R3
  hit_miss_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones({rsp_hit_o, rsp_miss_o}) == 1);
  // R4
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o && !rsp_fault_o |-> rsp_paddr_o[OFF_W-1:0] == $past(lkp_vaddr_i[OFF_W-1:0]));
  // R5
  fault_on_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> rsp_hit_o && rsp_paddr_o == '0);
  // R7
  full_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_valid_i && flush_all_i |=> valid_q == '0);
  // R11
  fill_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_valid_i && fill_valid_i && flush_all_i |=> valid_q == '0);
  // R9
  fill_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i && !flush_valid_i |=> valid_q != '0);
endmodule

bind asid_tlb asid_tlb_chk #(
  .N_ENTRIES(N_ENTRIES), .OFF_W(OFF_W), .VA_W(VA_W), .PA_W(PA_W)
) i_asid_tlb_chk (
  .clk_i, .rst_ni, .lkp_valid_i, .lkp_vaddr_i, .fill_valid_i, .flush_valid_i, .flush_all_i,
  .rsp_valid_o, .rsp_hit_o, .rsp_miss_o, .rsp_fault_o, .rsp_paddr_o, .rsp_dirty_o, .valid_q
);

// File: tb/test_asid_tlb.sv
module test_asid_tlb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic        lv = 0, fv = 0, flv = 0, fall = 0, fd = 0;
  logic [31:0] va = '0;
  logic [7:0]  la = '0, fa = '0, fla = '0;
  logic [1:0]  lacc = '0;
  logic [19:0] fvpn = '0, fppn = '0;
  logic [2:0]  fperm = '0;
  logic        r_valid, r_hit, r_miss, r_fault, r_dirty;
  logic [31:0] r_paddr;

  asid_tlb i_asid_tlb (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_valid_i(lv), .lkp_vaddr_i(va), .lkp_asid_i(la), .lkp_acc_i(lacc),
    .fill_valid_i(fv), .fill_vpn_i(fvpn), .fill_ppn_i(fppn), .fill_asid_i(fa),
    .fill_perm_i(fperm), .fill_dirty_i(fd),
    .flush_valid_i(flv), .flush_all_i(fall), .flush_asid_i(fla),
    .rsp_valid_o(r_valid), .rsp_hit_o(r_hit), .rsp_miss_o(r_miss),
    .rsp_fault_o(r_fault), .rsp_paddr_o(r_paddr), .rsp_dirty_o(r_dirty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  bit          m_valid[N], m_dirty[N];
  logic [19:0] m_vpn[N], m_ppn[N];
  logic [7:0]  m_asid[N];
  logic [2:0]  m_perm[N];
  int          rec[$];  // front = least recently used
  bit          e_valid, e_hit, e_miss, e_fault, e_dirty;
  logic [31:0] e_paddr;

  int    n_chk = 0, n_fail = 0;
  bit    cmp_en = 0;
  string scen = "R1";

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s [%s] t=%0t: actual %h expected %h", tag, scen, $time, act, exp);
    end
  endtask

  function automatic void touch(input int k);
    for (int j = 0; j < rec.size(); j++)
      if (rec[j] == k) begin rec.delete(j); break; end
    rec.push_back(k);
  endfunction

  function automatic bit allowed(input logic [2:0] p, input logic [1:0] a);
    if (a == 2'd0) return p[0];
    if (a == 2'd1) return p[1];
    if (a == 2'd2) return p[2];
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_valid[i] = 0; m_dirty[i] = 0; m_vpn[i] = '0; m_ppn[i] = '0; m_asid[i] = '0; m_perm[i] = '0;
      end
      rec.delete();
      for (int i = 0; i < N; i++) rec.push_back(i);
      e_valid = 0; e_hit = 0; e_miss = 0; e_fault = 0; e_dirty = 0; e_paddr = '0;
    end else begin
      int hi, fi;
      bit ok;
      hi = -1;
      for (int i = 0; i < N; i++)
        if (hi < 0 && m_valid[i] && m_vpn[i] == va[31:12] && m_asid[i] == la) hi = i;
      ok = (hi >= 0) ? allowed(m_perm[hi], lacc) : 1'b0;
      e_valid = lv;
      e_hit   = lv && hi >= 0;
      e_miss  = lv && hi < 0;
      e_fault = e_hit && !ok;
      e_paddr = (e_hit && ok) ? {m_ppn[hi], va[11:0]} : 32'h0;
      e_dirty = e_hit ? m_dirty[hi] : 1'b0;
      // victim chosen from start-of-cycle state
      fi = -1;
      for (int i = 0; i < N; i++)
        if (fi < 0 && m_valid[i] && m_vpn[i] == fvpn && m_asid[i] == fa) fi = i;
      if (fi < 0) for (int i = 0; i < N; i++) if (fi < 0 && !m_valid[i]) fi = i;
      if (fi < 0) fi = rec[0];
      if (e_hit) begin
        if (ok && lacc == 2'd1) m_dirty[hi] = 1;
        touch(hi);
      end
      if (fv && !flv) begin
        m_valid[fi] = 1; m_vpn[fi] = fvpn; m_ppn[fi] = fppn; m_asid[fi] = fa;
        m_perm[fi] = fperm; m_dirty[fi] = fd;
        touch(fi);
      end
      if (flv)
        for (int i = 0; i < N; i++)
          if (fall || m_asid[i] == fla) m_valid[i] = 0;
    end
  end

  // compare every cycle, half a period after the result edge
  always @(negedge clk) begin
    if (cmp_en) begin
      chk(r_valid == e_valid, "R2", 32'(r_valid), 32'(e_valid));
      chk(r_hit == e_hit && r_miss == e_miss, "R3", {r_hit, r_miss}, {e_hit, e_miss});
      chk(r_paddr == e_paddr, "R4", r_paddr, e_paddr);
      chk(r_fault == e_fault, "R5", 32'(r_fault), 32'(e_fault));
      chk(r_dirty == e_dirty, "R6", 32'(r_dirty), 32'(e_dirty));
    end
  end

  function automatic void clr();
    lv = 0; fv = 0; flv = 0;
  endfunction

  task automatic idle();
    @(negedge clk); clr();
  endtask
  task automatic lkp(input logic [19:0] vpn, input logic [11:0] off, input logic [7:0] asid, input logic [1:0] acc);
    @(negedge clk); clr();
    lv = 1; va = {vpn, off}; la = asid; lacc = acc;
  endtask
  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [7:0] asid,
                      input logic [2:0] perm, input bit dirty);
    @(negedge clk); clr();
    fv = 1; fvpn = vpn; fppn = ppn; fa = asid; fperm = perm; fd = dirty;
  endtask
  task automatic flush(input bit all, input logic [7:0] asid);
    @(negedge clk); clr();
    flv = 1; fall = all; fla = asid;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: outputs quiet during reset
    repeat (3) @(negedge clk);
    chk({r_valid, r_hit, r_miss, r_fault, r_dirty} == 5'b0 && r_paddr == '0, "R1",
        {r_valid, r_hit, r_miss, r_fault, r_dirty}, 32'h0);
    rst_n = 1;
    cmp_en = 1;
    scen = "R1";
    lkp(20'h00000, 12'h000, 8'h0, 2'd0);
    lkp(20'h12345, 12'h678, 8'h3, 2'd0);
    idle();
    @(negedge clk);
    chk(r_valid == 0, "R1", 32'(r_valid), 32'h0);

    scen = "R4";
    fill(20'h12345, 20'hABCDE, 8'h3, 3'b011, 1'b0);
    lkp(20'h12345, 12'h678, 8'h3, 2'd0);
    lkp(20'h12345, 12'hFFF, 8'h3, 2'd0);
    scen = "R3";
    lkp(20'h12345, 12'h678, 8'h4, 2'd0);
    lkp(20'h12346, 12'h678, 8'h3, 2'd0);
    scen = "R5";
    lkp(20'h12345, 12'h001, 8'h3, 2'd2);
    lkp(20'h12345, 12'h001, 8'h3, 2'd3);
    scen = "R6";
    lkp(20'h12345, 12'h010, 8'h3, 2'd1);
    lkp(20'h12345, 12'h010, 8'h3, 2'd0);
    fill(20'h00777, 20'h11111, 8'h3, 3'b101, 1'b0);
    lkp(20'h00777, 12'h020, 8'h3, 2'd1);
    lkp(20'h00777, 12'h020, 8'h3, 2'd0);
    lkp(20'h00777, 12'h020, 8'h3, 2'd2);
    fill(20'h00888, 20'h22222, 8'h3, 3'b111, 1'b1);
    lkp(20'h00888, 12'h030, 8'h3, 2'd0);

    scen = "R12";
    fill(20'h00999, 20'h33333, 8'h3, 3'b111, 1'b0);
    lv = 1; va = {20'h00999, 12'h040}; la = 8'h3; lacc = 2'd0;
    lkp(20'h00999, 12'h040, 8'h3, 2'd0);
    flush(1'b0, 8'h3);
    lv = 1; va = {20'h00999, 12'h041}; la = 8'h3; lacc = 2'd0;
    lkp(20'h00999, 12'h041, 8'h3, 2'd0);

    scen = "R10";
    fill(20'h00AAA, 20'h44444, 8'h7, 3'b001, 1'b0);
    fill(20'h00AAA, 20'h55555, 8'h7, 3'b011, 1'b1);
    lkp(20'h00AAA, 12'h050, 8'h7, 2'd1);
    lkp(20'h00AAA, 12'h050, 8'h8, 2'd0);

    scen = "R8";
    fill(20'h00100, 20'h60000, 8'h5, 3'b111, 1'b0);
    fill(20'h00101, 20'h60001, 8'h6, 3'b111, 1'b0);
    fill(20'h00100, 20'h60002, 8'h6, 3'b111, 1'b0);
    flush(1'b0, 8'h5);
    lkp(20'h00100, 12'h0, 8'h5, 2'd0);
    lkp(20'h00100, 12'h0, 8'h6, 2'd0);
    lkp(20'h00101, 12'h0, 8'h6, 2'd0);
    lkp(20'h00AAA, 12'h0, 8'h7, 2'd0);

    scen = "R7";
    flush(1'b1, 8'h0);
    lkp(20'h00100, 12'h0, 8'h6, 2'd0);
    lkp(20'h00AAA, 12'h0, 8'h7, 2'd0);

    scen = "R11";
    fill(20'h00200, 20'h70000, 8'h9, 3'b111, 1'b0);
    flv = 1; fall = 0; fla = 8'h1;
    lkp(20'h00200, 12'h0, 8'h9, 2'd0);

    scen = "R9";
    flush(1'b1, 8'h0);
    for (int i = 0; i < N; i++) fill(20'(i), 20'(20'h80000 + i), 8'h1, 3'b111, 1'b0);
    lkp(20'h0, 12'h0, 8'h1, 2'd0);
    fill(20'd100, 20'h9000A, 8'h1, 3'b111, 1'b0);
    lkp(20'h1, 12'h0, 8'h1, 2'd0);
    lkp(20'h0, 12'h0, 8'h1, 2'd0);
    lkp(20'h2, 12'h0, 8'h1, 2'd2);
    fill(20'd101, 20'h9000B, 8'h1, 3'b111, 1'b0);
    lv = 1; va = {20'h3, 12'h0}; la = 8'h1; lacc = 2'd0;
    fill(20'd102, 20'h9000C, 8'h1, 3'b111, 1'b0);
    for (int i = 0; i < 6; i++) lkp(20'(i), 12'h0, 8'h1, 2'd0);
    flush(1'b0, 8'h1);
    fill(20'd7, 20'h9000D, 8'h2, 3'b111, 1'b0);
    lkp(20'd7, 12'h0, 8'h2, 2'd0);

    scen = "R9/R10/R12 mix";
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk); clr();
      lv = ($urandom_range(0, 2) != 0);
      va = {20'($urandom_range(0, 23)), 12'($urandom)};
      la = 8'($urandom_range(0, 2)); lacc = 2'($urandom_range(0, 3));
      fv = ($urandom_range(0, 3) == 0);
      fvpn = 20'($urandom_range(0, 23)); fppn = 20'($urandom); fa = 8'($urandom_range(0, 2));
      fperm = 3'($urandom); fd = 1'($urandom);
      flv = ($urandom_range(0, 40) == 0); fall = 1'($urandom); fla = 8'($urandom_range(0, 2));
    end
    idle();
    idle();
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule